// File: doc/BRIEF.md
# Keyed watchdog with cross-domain refresh

This block is a watchdog timer that software controls over a simple register bus in the bus clock domain. The timeout counter runs in its own counter domain. That domain is clocked by either a free-running slow oscillator or the bus clock, and a programmable prescaler then divides it into count ticks. The configuration registers take writes only while an access window is open. Software opens the window with a two-word unlock key.

Software keeps the system alive by writing a two-word refresh key. A completed key is only a request. It travels into the counter domain through a toggle handshake and clears the count a few counter ticks later. A new key that completes while the previous request is still in flight is discarded. If the count reaches the programmed timeout, a sticky reset request is raised. A refresh key that is started but not finished correctly raises the reset request at once.

Top module: `keyed_wdog`

## Requirements
- R1: After reset, control (address 0) reads 0x01D2: bit 0 enable = 0, bit 1 clock select = 1 (bus clock), bit 4 allow-update = 1. Timeout high (address 1) reads 0x0000, timeout low (address 2) reads 0x1000, prescale (address 3) reads 0, and reset_req is low.
- R2: Writes to addresses 0 to 3 are ignored unless the window is open. The window opens only when address 4 receives 0xC520 and the very next bus access is a write of 0xD928 to address 4. Any other access between the two words cancels the unlock.
- R3: A write to control in the bus cycle directly after the unlock completes is ignored. A write to control one cycle later is accepted.
- R4: The window stays open for 256 bus cycles after the unlock completes. It closes early after a control write whose bit 4 is 0.
- R5: When enabled, the refresh key (0xA602 and then 0xB480 on the next access, both to address 5) restarts the count within three counter ticks. Refreshing at intervals shorter than the timeout keeps reset_req low.
- R6: While enabled, once 0xA602 has been written to address 5, any next access that is not a write of 0xB480 to address 5 raises reset_req within two bus cycles. While disabled, the same sequence has no effect.
- R7: With bit 0 set, the count advances once per tick. reset_req rises when the count reaches the timeout value {high, low} and then stays high until bus reset.
- R8: The prescale field (bits 2:0 of address 3) divides the selected clock by its value plus one to form the count tick.
- R9: Clock select (control bit 1) set to 1 clocks the counter domain from the bus clock. Set to 0, it uses slow_clk.
- R10: A refresh key that completes while an earlier refresh is still crossing into the counter domain is dropped and does not restart the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Bus clock |
| bus_rst_n | input | 1 | Active-low asynchronous reset for both domains |
| slow_clk | input | 1 | Slow free-running oscillator, selectable as the counter clock |
| bus_valid | input | 1 | Bus access strobe, one access per cycle |
| bus_write | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for addresses 0 to 3, combinational on bus_addr |
| reset_req | output | 1 | Sticky reset request from timeout or a broken refresh key |

## Verification
The timeout is measured for several clock sources and divisors: the bus clock with no division, the bus clock divided by four, and the slow oscillator. Each measurement is bracketed by an early sample that must be low and a late sample that must be high, so a wrong source or divisor moves the edge outside the bracket. Refresh is tried three ways: spaced well under the timeout, where the output must stay low; two keys back to back, where only the first may restart the count; and keys that are broken in different ways. The unlock sweep covers the correct key, a key with an access in between, a control write in the blocked cycle, writes on both sides of the window expiry, and an early close through allow-update.

// File: rtl/wdk_pkg.sv
package wdk_pkg;
  localparam int DW = 16;
  localparam int AW = 3;

  typedef enum logic [AW-1:0] {
    A_CTRL    = 3'd0,
    A_TOHI    = 3'd1,
    A_TOLO    = 3'd2,
    A_PRESC   = 3'd3,
    A_UNLOCK  = 3'd4,
    A_REFRESH = 3'd5
  } addr_e;

  localparam logic [DW-1:0] UNLOCK_KEY_A  = 16'hC520;
  localparam logic [DW-1:0] UNLOCK_KEY_B  = 16'hD928;
  localparam logic [DW-1:0] REFRESH_KEY_A = 16'hA602;
  localparam logic [DW-1:0] REFRESH_KEY_B = 16'hB480;

  localparam int B_EN    = 0;
  localparam int B_SEL   = 1;
  localparam int B_ALLOW = 4;

  // count has reached or passed the programmed limit
  function automatic logic limit_hit(input logic [2*DW-1:0] count,
                                     input logic [2*DW-1:0] limit);
    return count >= limit;
  endfunction

  // prescaler phase is at the end of its divide-by-(p+1) period
  function automatic logic phase_end(input logic [7:0] phase, input logic [7:0] p);
    return phase >= p;
  endfunction
endpackage

// File: rtl/wdk_keyseq.sv
module wdk_keyseq #(
  parameter int DW = 16,
  parameter logic [DW-1:0] KEY_A = '0,
  parameter logic [DW-1:0] KEY_B = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          access,
  input  logic          hit,
  input  logic [DW-1:0] data,
  output logic          done,
  output logic          aborted
);
  logic armed;
  logic first_ok, second_ok;

  assign first_ok  = hit && (data == KEY_A);
  assign second_ok = hit && (data == KEY_B);
  assign done      = access && armed && second_ok;
  assign aborted   = access && armed && !second_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      armed <= 1'b0;
    else if (access) armed <= first_ok;
  end

  // R2 / R5: a completed key always follows an access carrying the first word
  assert_key_order_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(access && hit && data == KEY_A));
endmodule

// File: rtl/wdk_regs.sv
module wdk_regs
  import wdk_pkg::*;
#(
  parameter int CW = 32,
  parameter int PW = 3,
  parameter int WIN = 256,
  parameter logic [DW-1:0] CTRL_RST = 16'h01D2,
  parameter logic [CW-1:0] TOV_RST = 32'h0000_1000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_valid,
  input  logic          bus_write,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic [DW-1:0] ctrl,
  output logic [CW-1:0] tov,
  output logic [PW-1:0] presc,
  output logic          refresh_cmd,
  output logic          brk_req,
  output logic          win_open
);
  localparam int WCW = $clog2(WIN + 1);

  logic wr_any, hit_unlock, hit_refresh;
  logic unlock_done, unused_unlock_abort;
  logic ref_abort;
  logic just_opened;
  logic [WCW-1:0] win_cnt;
  logic cfg_we, ctrl_we;

  assign wr_any      = bus_valid && bus_write;
  assign hit_unlock  = wr_any && (bus_addr == A_UNLOCK);
  assign hit_refresh = wr_any && (bus_addr == A_REFRESH);

  wdk_keyseq #(.DW(DW), .KEY_A(UNLOCK_KEY_A), .KEY_B(UNLOCK_KEY_B)) u_unlock (
    .clk(clk), .rst_n(rst_n), .access(bus_valid), .hit(hit_unlock),
    .data(bus_wdata), .done(unlock_done), .aborted(unused_unlock_abort));

  wdk_keyseq #(.DW(DW), .KEY_A(REFRESH_KEY_A), .KEY_B(REFRESH_KEY_B)) u_refresh (
    .clk(clk), .rst_n(rst_n), .access(bus_valid), .hit(hit_refresh),
    .data(bus_wdata), .done(refresh_cmd), .aborted(ref_abort));

  assign win_open = (win_cnt != '0);
  assign cfg_we   = wr_any && win_open;
  assign ctrl_we  = cfg_we && (bus_addr == A_CTRL) && !just_opened;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      just_opened <= 1'b0;
      win_cnt     <= '0;
    end else begin
      just_opened <= unlock_done;
      if (unlock_done)                        win_cnt <= WCW'(WIN);
      else if (ctrl_we && !bus_wdata[B_ALLOW]) win_cnt <= '0;
      else if (win_open)                      win_cnt <= win_cnt - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl  <= CTRL_RST;
      tov   <= TOV_RST;
      presc <= '0;
    end else begin
      if (ctrl_we) ctrl <= bus_wdata;
      if (cfg_we && bus_addr == A_TOHI)  tov[CW-1:DW] <= bus_wdata;
      if (cfg_we && bus_addr == A_TOLO)  tov[DW-1:0]  <= bus_wdata;
      if (cfg_we && bus_addr == A_PRESC) presc        <= bus_wdata[PW-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      brk_req <= 1'b0;
    else if (ref_abort && ctrl[B_EN]) brk_req <= 1'b1;
  end

  always_comb begin
    case (bus_addr)
      A_CTRL:  bus_rdata = ctrl;
      A_TOHI:  bus_rdata = tov[CW-1:DW];
      A_TOLO:  bus_rdata = tov[DW-1:0];
      A_PRESC: bus_rdata = {{(DW-PW){1'b0}}, presc};
      default: bus_rdata = '0;
    endcase
  end

  // R2: nothing in the configuration moves while the window is shut
  assert_locked_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !win_open |=> ($stable(ctrl) && $stable(tov) && $stable(presc)));
  // R3: the cycle right after an unlock cannot change control
  assert_ctrl_guard_R3: assert property (@(posedge clk) disable iff (!rst_n)
    unlock_done |-> ##2 $stable(ctrl));
  // R6: a broken refresh key under enable raises the request next cycle
  assert_broken_key_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_abort && ctrl[B_EN]) |=> brk_req);
  // R4: an unlock always leaves the window open on the following cycle
  assert_window_opens_R4: assert property (@(posedge clk) disable iff (!rst_n)
    unlock_done |=> win_open);
endmodule

// File: rtl/wdk_cdc.sv
module wdk_cdc #(
  parameter int STAGES = 2
) (
  input  logic bus_clk,
  input  logic rst_n,
  input  logic refresh_cmd,
  output logic busy,
  input  logic cnt_clk,
  input  logic cnt_tick,
  output logic refresh_evt
);
  logic              req_tgl;
  logic [STAGES-1:0] fwd_sync;
  logic              fwd_seen;
  logic [STAGES-1:0] back_sync;

  assign busy = (req_tgl != back_sync[STAGES-1]);

  always_ff @(posedge bus_clk or negedge rst_n) begin
    if (!rst_n) begin
      req_tgl   <= 1'b0;
      back_sync <= '0;
    end else begin
      if (refresh_cmd && !busy) req_tgl <= ~req_tgl;
      back_sync <= {back_sync[STAGES-2:0], fwd_seen};
    end
  end

  always_ff @(posedge cnt_clk or negedge rst_n) begin
    if (!rst_n) begin
      fwd_sync <= '0;
      fwd_seen <= 1'b0;
    end else if (cnt_tick) begin
      fwd_sync <= {fwd_sync[STAGES-2:0], req_tgl};
      fwd_seen <= fwd_sync[STAGES-1];
    end
  end

  assign refresh_evt = cnt_tick && (fwd_sync[STAGES-1] != fwd_seen);

  // R10: a key completing during a crossing leaves the request flag alone
  assert_drop_in_flight_R10: assert property (@(posedge bus_clk) disable iff (!rst_n)
    (refresh_cmd && busy) |=> $stable(req_tgl));
  // R5: one request yields one restart event in the counter domain
  assert_single_event_R5: assert property (@(posedge cnt_clk) disable iff (!rst_n)
    refresh_evt |=> !refresh_evt);
endmodule

// File: rtl/wdk_counter.sv
module wdk_counter
  import wdk_pkg::*;
#(
  parameter int CW = 32,
  parameter int PW = 3
) (
  input  logic          cnt_clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic [PW-1:0] presc,
  input  logic [CW-1:0] tov,
  input  logic          refresh_evt,
  output logic          tick,
  output logic          expired
);
  logic [PW-1:0] phase;
  logic [CW-1:0] count;

  assign tick = phase_end(8'(phase), 8'(presc));

  always_ff @(posedge cnt_clk or negedge rst_n) begin
    if (!rst_n) phase <= '0;
    else        phase <= tick ? '0 : phase + 1'b1;
  end

  always_ff @(posedge cnt_clk or negedge rst_n) begin
    if (!rst_n) begin
      count   <= '0;
      expired <= 1'b0;
    end else if (!enable) begin
      count <= '0;
    end else if (tick) begin
      if (refresh_evt) count <= '0;
      else if (!expired && count != {CW{1'b1}}) count <= count + 1'b1;
      if (!refresh_evt && limit_hit(count, tov)) expired <= 1'b1;
    end
  end

  // R7: a timeout is held until reset
  assert_expired_sticky_R7: assert property (@(posedge cnt_clk) disable iff (!rst_n)
    expired |=> expired);
  // R5: a restart event under enable leaves the count at zero
  assert_restart_clears_R5: assert property (@(posedge cnt_clk) disable iff (!rst_n)
    (refresh_evt && enable) |=> (count == '0));
endmodule

// File: rtl/keyed_wdog.sv
module keyed_wdog
  import wdk_pkg::*;
#(
  parameter int PW = 3,
  parameter int WIN = 256,
  parameter int SYNC_STAGES = 2
) (
  input  logic          bus_clk,
  input  logic          bus_rst_n,
  input  logic          slow_clk,
  input  logic          bus_valid,
  input  logic          bus_write,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          reset_req
);
  localparam int CW = 2 * DW;

  logic [DW-1:0] ctrl;
  logic [CW-1:0] tov;
  logic [PW-1:0] presc;
  logic refresh_cmd, brk_req, win_open;
  logic cnt_clk, tick, refresh_evt, busy, expired;

  wdk_regs #(.CW(CW), .PW(PW), .WIN(WIN)) u_regs (
    .clk(bus_clk), .rst_n(bus_rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ctrl(ctrl), .tov(tov), .presc(presc), .refresh_cmd(refresh_cmd),
    .brk_req(brk_req), .win_open(win_open));

  assign cnt_clk = ctrl[B_SEL] ? bus_clk : slow_clk;

  wdk_cdc #(.STAGES(SYNC_STAGES)) u_cdc (
    .bus_clk(bus_clk), .rst_n(bus_rst_n), .refresh_cmd(refresh_cmd), .busy(busy),
    .cnt_clk(cnt_clk), .cnt_tick(tick), .refresh_evt(refresh_evt));

  wdk_counter #(.CW(CW), .PW(PW)) u_cnt (
    .cnt_clk(cnt_clk), .rst_n(bus_rst_n), .enable(ctrl[B_EN]), .presc(presc),
    .tov(tov), .refresh_evt(refresh_evt), .tick(tick), .expired(expired));

  assign reset_req = brk_req | expired;

  // R7 / R6: once raised, the request holds until bus reset
  assert_request_holds_R7: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
    reset_req |=> reset_req);
  // R2: the window can only be open after some unlock has been seen
  assert_window_source_R2: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
    $rose(win_open) |-> $past(bus_valid && bus_write && bus_addr == A_UNLOCK));
endmodule

// File: tb/sim_keyed_wdog.sv
module sim_keyed_wdog;
  import wdk_pkg::*;

  logic bus_clk = 1'b0, slow_clk = 1'b0, bus_rst_n = 1'b0;
  logic bus_valid = 1'b0, bus_write = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] bus_rdata;
  logic reset_req;
  int checks = 0, errors = 0;

  always #2 bus_clk = ~bus_clk;
  always #20 slow_clk = ~slow_clk;

  keyed_wdog u0 (
    .bus_clk(bus_clk), .bus_rst_n(bus_rst_n), .slow_clk(slow_clk),
    .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .reset_req(reset_req));

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge bus_clk);
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge bus_clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] d);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge bus_clk);
    bus_valid = 1'b0;
  endtask

  task automatic expect_reg(input logic [AW-1:0] a, input logic [DW-1:0] exp,
                            input string tag);
    logic [DW-1:0] v;
    rd(a, v);
    check(v == exp, tag, 32'(v), 32'(exp));
  endtask

  task automatic expect_req(input logic exp, input string tag);
    check(reset_req == exp, tag, 32'(reset_req), 32'(exp));
  endtask

  task automatic do_reset();
    bus_rst_n = 1'b0; idle(3); bus_rst_n = 1'b1; idle(2);
  endtask

  task automatic unlock();
    wr(A_UNLOCK, 16'hC520); wr(A_UNLOCK, 16'hD928);
  endtask

  task automatic refresh();
    wr(A_REFRESH, 16'hA602); wr(A_REFRESH, 16'hB480);
  endtask

  task automatic setup(input logic [DW-1:0] hi, input logic [DW-1:0] lo,
                       input logic [DW-1:0] p, input logic [DW-1:0] c);
    unlock(); wr(A_TOHI, hi); wr(A_TOLO, lo); wr(A_PRESC, p); wr(A_CTRL, c);
  endtask

  initial begin
    repeat (150000) @(posedge bus_clk);
    checks++; errors++;
    $display("FAIL watchdog: run did not complete, actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    idle(3); bus_rst_n = 1'b1; idle(2);

    // R1 reset state
    expect_reg(A_CTRL, 16'h01D2, "R1 control reset");
    expect_reg(A_TOHI, 16'h0000, "R1 timeout high reset");
    expect_reg(A_TOLO, 16'h1000, "R1 timeout low reset");
    expect_reg(A_PRESC, 16'h0000, "R1 prescale reset");
    expect_req(1'b0, "R1 reset_req after reset");

    // R2 locked write ignored, interrupted unlock ignored, good unlock works
    wr(A_TOLO, 16'h0123);
    expect_reg(A_TOLO, 16'h1000, "R2 locked write ignored");
    begin
      logic [DW-1:0] tmp;
      wr(A_UNLOCK, 16'hC520); rd(A_CTRL, tmp); wr(A_UNLOCK, 16'hD928);
    end
    wr(A_TOLO, 16'h0456);
    expect_reg(A_TOLO, 16'h1000, "R2 interrupted unlock stays locked");
    wr(A_UNLOCK, 16'hC520); wr(A_UNLOCK, 16'h1111);
    wr(A_TOLO, 16'h0457);
    expect_reg(A_TOLO, 16'h1000, "R2 wrong second word stays locked");
    unlock(); wr(A_TOHI, 16'h0001); wr(A_TOLO, 16'h0022);
    expect_reg(A_TOHI, 16'h0001, "R2 unlocked high write");
    expect_reg(A_TOLO, 16'h0022, "R2 unlocked low write");

    // R3 control write in the cycle after unlock
    do_reset();
    unlock(); wr(A_CTRL, 16'h01C3);
    expect_reg(A_CTRL, 16'h01D2, "R3 control write right after unlock ignored");
    unlock(); wr(A_PRESC, 16'h0000); wr(A_CTRL, 16'h01D0);
    expect_reg(A_CTRL, 16'h01D0, "R3 control write one cycle later accepted");

    // R4 window expiry and early close
    do_reset();
    unlock(); idle(200); wr(A_TOLO, 16'h0055);
    expect_reg(A_TOLO, 16'h0055, "R4 write inside window");
    idle(60); wr(A_TOLO, 16'h0066);
    expect_reg(A_TOLO, 16'h0055, "R4 write after window expiry ignored");
    do_reset();
    unlock(); wr(A_TOHI, 16'h0000); wr(A_CTRL, 16'h01C2); wr(A_TOLO, 16'h0077);
    expect_reg(A_TOLO, 16'h1000, "R4 allow-update 0 closes window");
    expect_reg(A_CTRL, 16'h01C2, "R4 closing control write itself taken");

    // R7 / R9 timeout on bus clock, no division, limit 40
    do_reset();
    setup(16'h0000, 16'd40, 16'h0000, 16'h01D3);
    idle(38); expect_req(1'b0, "R7 low before limit");
    idle(5);  expect_req(1'b1, "R7 high after limit (bus clock R9)");
    idle(20); expect_req(1'b1, "R7 request sticky");

    // R8 prescale 3 on bus clock, limit 10: about 44 cycles
    do_reset();
    setup(16'h0000, 16'd10, 16'h0003, 16'h01D3);
    idle(36); expect_req(1'b0, "R8 divided count still below limit");
    idle(16); expect_req(1'b1, "R8 divided count reached limit");

    // R9 slow clock (ten bus cycles per period), limit 10: about 110-130 cycles
    do_reset();
    setup(16'h0000, 16'd10, 16'h0000, 16'h01D1);
    idle(90); expect_req(1'b0, "R9 slow clock not yet expired");
    idle(60); expect_req(1'b1, "R9 slow clock expired");

    // R5 spaced refreshes keep it alive, then stopping lets it expire
    do_reset();
    setup(16'h0000, 16'd40, 16'h0000, 16'h01D3);
    for (int i = 0; i < 20; i++) begin
      refresh(); idle(14);
    end
    expect_req(1'b0, "R5 spaced refresh keeps request low");
    idle(25); expect_req(1'b0, "R5 last restart still counting");
    idle(6);  expect_req(1'b1, "R5 expiry after refreshes stop");

    // R10 back-to-back refresh: only the first restarts the count
    do_reset();
    setup(16'h0000, 16'd40, 16'h0000, 16'h01D3);
    idle(10);
    refresh(); refresh();
    idle(38); expect_req(1'b0, "R10 first refresh restarted count");
    idle(4);  expect_req(1'b1, "R10 second refresh dropped");

    // R6 broken refresh keys
    do_reset();
    unlock(); wr(A_PRESC, 16'h0000); wr(A_CTRL, 16'h01D3);
    wr(A_REFRESH, 16'hA602);
    expect_req(1'b0, "R6 no request after first word alone");
    begin
      logic [DW-1:0] tmp;
      rd(A_CTRL, tmp);
    end
    idle(2); expect_req(1'b1, "R6 read between key words raises request");
    do_reset();
    unlock(); wr(A_PRESC, 16'h0000); wr(A_CTRL, 16'h01D3);
    wr(A_REFRESH, 16'hA602); wr(A_REFRESH, 16'h1234);
    idle(2); expect_req(1'b1, "R6 wrong second word raises request");
    do_reset();
    wr(A_REFRESH, 16'hA602); wr(A_TOLO, 16'h0001);
    idle(4); expect_req(1'b0, "R6 broken key ignored while disabled");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule